// File: doc/BRIEF.md
# Interrupt and Cycle-Steal Poll Responder

This block is the device-side logic that answers a daisy-chained poll on a channel interface. It holds two pending-request flags, one for cycle-steal service and one for an interrupt. It also holds a priority level and an interrupt-enable flag, both written by a configuration (Prepare) load. While an interrupt is pending and enabled, the block raises the single request-bus line that matches its stored level.

When a poll arrives, the block looks at an active-low class bit. A low value asks for cycle-steal service and also covers the quiescent and reserved codes. A high value asks for an interrupt at the level given by the four poll-level bits.

If the block has a matching request, it claims the poll by setting a hold flag and does not pass the poll on. In every other case it passes the poll to the next device one clock later. The hold flag stays set until a release pulse arrives from the service-gate capture logic.

Top module: `poll_responder`

## Requirements
- R1: After reset, `reqin_bus`, `cs_req_out`, `poll_pass`, `poll_held` and `held_irq` are all 0, and the stored enable is 0.
- R2: A cycle with `prep_load` high stores `prep_level` and `prep_ien`. The new values govern `reqin_bus` and poll matching from the following cycle.
- R3: `reqin_bus` bit i (bit 0 is the least significant) is 1 exactly when an interrupt is pending, the stored enable is 1 and the stored level equals i. All other bits are 0.
- R4: Each request flag is set one cycle after its set input is high and cleared one cycle after its clear input is high; when both are high, the clear wins. `cs_req_out` shows the cycle-steal flag.
- R5: A poll with `poll_cs_n` = 0, while the cycle-steal flag is set and nothing is held, makes `poll_held` 1 and `held_irq` 0 one cycle later, with `poll_pass` staying 0.
- R6: A poll with `poll_cs_n` = 0 and no cycle-steal flag set (the quiescent or reserved case) is never claimed: `poll_pass` is 1 one cycle later and `poll_held` stays 0.
- R7: A poll with `poll_cs_n` = 1 is claimed only if an interrupt is pending, the enable is 1 and `poll_level` equals the stored level. It then gives `poll_held` = 1 and `held_irq` = 1 one cycle later. In every other case it gives `poll_pass` = 1 one cycle later.
- R8: While `poll_held` is 1, every poll is passed on, and `poll_held` stays 1 until `cap_release` is high. It then clears on the next cycle.
- R9: `poll_pass` is 0 in the cycle after one in which `poll_active` was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prep_load | input | 1 | Prepare load strobe |
| prep_level | input | LVL_W | Interrupt level to store |
| prep_ien | input | 1 | Interrupt enable to store |
| cs_set | input | 1 | Set cycle-steal request |
| cs_clr | input | 1 | Clear cycle-steal request |
| irq_set | input | 1 | Set interrupt request |
| irq_clr | input | 1 | Clear interrupt request |
| poll_active | input | 1 | Poll presented to this device |
| poll_cs_n | input | 1 | Active-low poll class bit (0 = cycle-steal/quiescent) |
| poll_level | input | LVL_W | Level being polled |
| cap_release | input | 1 | Clears the hold flag |
| reqin_bus | output | 2**LVL_W | One-hot interrupt request lines |
| cs_req_out | output | 1 | Cycle-steal request to the interface |
| poll_pass | output | 1 | Poll propagated downstream |
| poll_held | output | 1 | Poll captured by this device |
| held_irq | output | 1 | Captured poll was an interrupt poll |

## Verification
A wrong stored level or enable shows up on `reqin_bus` in the cycle after the load, as a wrong line, as a second line, or as a missing line. A wrong class decode or a wrong level compare shows up one cycle after the poll: either both `poll_pass` and `poll_held` are wrong together, or `held_irq` has the wrong value. A hold flag that clears too early or too late is visible on the next poll, which must be passed while the flag is held, and in the cycle after a release.

// File: rtl/poll_pkg.sv
// Package: shared kind encoding for the poll responder.
// Assumes: a held poll is either cycle-steal or interrupt, nothing else.
package poll_pkg;
    typedef enum logic {
        KIND_CS  = 1'b0,
        KIND_IRQ = 1'b1
    } poll_kind_e;
endpackage

// File: rtl/prep_store.sv
// Module: holds the interrupt level and enable written by a Prepare load.
// Assumes: a load takes effect on the next clock; reset disables interrupts.
module prep_store #(
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LVL_W-1:0] level_in,
    input  logic             ien_in,
    output logic [LVL_W-1:0] level_q,
    output logic             ien_q
);
    // Capture the Prepare fields on a load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= '0;
            ien_q   <= 1'b0;
        end else if (load) begin
            level_q <= level_in;
            ien_q   <= ien_in;
        end
    end
endmodule

// File: rtl/req_flag.sv
// Module: one pending-request latch with synchronous set and clear.
// Assumes: clear has priority over set when both arrive in one cycle.
module req_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_q
);
    // Update the pending flag, giving clear the priority.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_q <= 1'b0;
        else if (clr_i) flag_q <= 1'b0;
        else if (set_i) flag_q <= 1'b1;
    end
endmodule

// File: rtl/level_drive.sv
// Module: decodes the stored level onto one request-bus line.
// Assumes: purely combinational; output is zero while not gated.
module level_drive #(
    parameter int LVL_W  = 4,
    parameter int NLINES = 1 << LVL_W
) (
    input  logic [LVL_W-1:0]  level,
    input  logic              gate,
    output logic [NLINES-1:0] lines
);
    // One comparator per request line.
    for (genvar i = 0; i < NLINES; i++) begin : g_line
        assign lines[i] = gate && (level == LVL_W'(i));
    end
endmodule

// File: rtl/poll_claim.sv
// Module: decides whether a poll is claimed or passed, and holds a claim.
// Assumes: a held claim blocks new claims; release has priority over set.
module poll_claim
    import poll_pkg::*;
#(
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             poll_active,
    input  logic             poll_cs_n,
    input  logic [LVL_W-1:0] poll_level,
    input  logic             cs_pend,
    input  logic             irq_pend,
    input  logic             ien,
    input  logic [LVL_W-1:0] level,
    input  logic             release_i,
    output logic             pass_q,
    output logic             held_q,
    output poll_kind_e       kind_q
);
    logic cs_hit;
    logic irq_hit;
    logic claim;

    // Classify the poll and test it against the pending requests.
    always_comb begin
        cs_hit  = !poll_cs_n && cs_pend;
        irq_hit = poll_cs_n && irq_pend && ien && (poll_level == level);
        claim   = poll_active && !held_q && (cs_hit || irq_hit);
    end

    // Hold flag and kind of the captured poll.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= 1'b0;
            kind_q <= KIND_CS;
        end else if (release_i) begin
            held_q <= 1'b0;
        end else if (claim) begin
            held_q <= 1'b1;
            kind_q <= irq_hit ? KIND_IRQ : KIND_CS;
        end
    end

    // Pass the poll downstream when not claimed.
    always_ff @(posedge clk) begin
        if (!rst_n) pass_q <= 1'b0;
        else        pass_q <= poll_active && !claim;
    end
endmodule

// File: rtl/poll_responder.sv
// Module: top of the poll responder; joins Prepare storage, request
// latches, request-bus decode and poll claim logic.
// Assumes: a single adapter; one poll in flight at a time.
module poll_responder
    import poll_pkg::*;
#(
    parameter int LVL_W = 4,
    localparam int NLINES = 1 << LVL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prep_load,
    input  logic [LVL_W-1:0]  prep_level,
    input  logic              prep_ien,
    input  logic              cs_set,
    input  logic              cs_clr,
    input  logic              irq_set,
    input  logic              irq_clr,
    input  logic              poll_active,
    input  logic              poll_cs_n,
    input  logic [LVL_W-1:0]  poll_level,
    input  logic              cap_release,
    output logic [NLINES-1:0] reqin_bus,
    output logic              cs_req_out,
    output logic              poll_pass,
    output logic              poll_held,
    output logic              held_irq
);
    logic [LVL_W-1:0] level_q;
    logic             ien_q;
    logic             cs_pend;
    logic             irq_pend;
    poll_kind_e       kind_q;

    prep_store #(.LVL_W(LVL_W)) u_prep (
        .clk(clk), .rst_n(rst_n), .load(prep_load),
        .level_in(prep_level), .ien_in(prep_ien),
        .level_q(level_q), .ien_q(ien_q)
    );

    req_flag u_cs (
        .clk(clk), .rst_n(rst_n), .set_i(cs_set), .clr_i(cs_clr), .flag_q(cs_pend)
    );

    req_flag u_irq (
        .clk(clk), .rst_n(rst_n), .set_i(irq_set), .clr_i(irq_clr), .flag_q(irq_pend)
    );

    level_drive #(.LVL_W(LVL_W), .NLINES(NLINES)) u_drive (
        .level(level_q), .gate(irq_pend && ien_q), .lines(reqin_bus)
    );

    poll_claim #(.LVL_W(LVL_W)) u_claim (
        .clk(clk), .rst_n(rst_n), .poll_active(poll_active),
        .poll_cs_n(poll_cs_n), .poll_level(poll_level),
        .cs_pend(cs_pend), .irq_pend(irq_pend), .ien(ien_q), .level(level_q),
        .release_i(cap_release), .pass_q(poll_pass), .held_q(poll_held),
        .kind_q(kind_q)
    );

    // Present the cycle-steal request and the captured kind.
    always_comb begin
        cs_req_out = cs_pend;
        held_irq   = (kind_q == KIND_IRQ) && poll_held;
    end
endmodule

// File: rtl/poll_responder_chk.sv
// Module: property checker for the poll responder, attached by bind.
// Assumes: sees the top ports plus the two request flags.
module poll_responder_chk #(
    parameter int LVL_W = 4,
    parameter int NLINES = 1 << LVL_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              poll_active,
    input logic              poll_cs_n,
    input logic              cap_release,
    input logic [NLINES-1:0] reqin_bus,
    input logic              poll_pass,
    input logic              poll_held,
    input logic              held_irq,
    input logic              cs_pend,
    input logic              irq_pend
);
    assert_bus_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reqin_bus));

    assert_bus_needs_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reqin_bus != '0) |-> irq_pend);

    assert_cs_claim_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_active && !poll_cs_n && cs_pend && !poll_held && !cap_release)
        |=> (poll_held && !held_irq && !poll_pass));

    assert_quiescent_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_active && !poll_cs_n && !cs_pend && !poll_held)
        |=> (poll_pass && !$rose(poll_held)));

    assert_release_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cap_release |=> !poll_held);

    assert_hold_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_held && !cap_release) |=> poll_held);

    assert_held_passes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_held && !cap_release && poll_active) |=> poll_pass);

    assert_idle_no_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !poll_active |=> !poll_pass);
endmodule

bind poll_responder poll_responder_chk #(.LVL_W(LVL_W), .NLINES(NLINES)) u_chk (
    .clk(clk), .rst_n(rst_n), .poll_active(poll_active), .poll_cs_n(poll_cs_n),
    .cap_release(cap_release), .reqin_bus(reqin_bus), .poll_pass(poll_pass),
    .poll_held(poll_held), .held_irq(held_irq), .cs_pend(cs_pend),
    .irq_pend(irq_pend)
);

// File: tb/sim_poll_responder.sv
module sim_poll_responder;
    localparam int LW = 4;
    localparam int NL = 1 << LW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prep_load = 0, prep_ien = 0;
    logic [LW-1:0] prep_level = '0, poll_level = '0;
    logic cs_set = 0, cs_clr = 0, irq_set = 0, irq_clr = 0;
    logic poll_active = 0, poll_cs_n = 1, cap_release = 0;
    logic [NL-1:0] reqin_bus;
    logic cs_req_out, poll_pass, poll_held, held_irq;
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    poll_responder #(.LVL_W(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .prep_load(prep_load), .prep_level(prep_level),
        .prep_ien(prep_ien), .cs_set(cs_set), .cs_clr(cs_clr), .irq_set(irq_set),
        .irq_clr(irq_clr), .poll_active(poll_active), .poll_cs_n(poll_cs_n),
        .poll_level(poll_level), .cap_release(cap_release), .reqin_bus(reqin_bus),
        .cs_req_out(cs_req_out), .poll_pass(poll_pass), .poll_held(poll_held),
        .held_irq(held_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic quiet();
        prep_load = 0; cs_set = 0; cs_clr = 0; irq_set = 0; irq_clr = 0;
        poll_active = 0; cap_release = 0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk); tick(); tick();
        rst_n = 1'b1;
        tick();
        // R1: reset state
        check("R1 bus", 32'(reqin_bus), 0);
        check("R1 cs", 32'(cs_req_out), 0);
        check("R1 pass", 32'(poll_pass), 0);
        check("R1 held", 32'(poll_held), 0);
        check("R1 kind", 32'(held_irq), 0);

        // R2 R3 R7: sweep stored level, polled level, enable, pending
        for (int l = 0; l < NL; l++) begin
            for (int p = 0; p < NL; p++) begin
                for (int e = 0; e < 2; e++) begin
                    for (int q = 0; q < 2; q++) begin
                        logic hit;
                        hit = (q == 1) && (e == 1) && (l == p);
                        prep_load = 1; prep_level = LW'(l); prep_ien = e[0];
                        irq_set = q[0]; irq_clr = !q[0]; cs_clr = 1; cap_release = 1;
                        tick(); quiet();
                        check("R2 R3 bus", 32'(reqin_bus),
                              (q == 1 && e == 1) ? (32'd1 << l) : 32'd0);
                        poll_active = 1; poll_cs_n = 1; poll_level = LW'(p);
                        tick(); quiet();
                        check("R7 held", 32'(poll_held), 32'(hit));
                        check("R7 pass", 32'(poll_pass), 32'(!hit));
                        check("R7 kind", 32'(held_irq), 32'(hit));
                        tick();
                        check("R9 idle pass", 32'(poll_pass), 0);
                        check("R8 kept", 32'(poll_held), 32'(hit));
                    end
                end
            end
        end

        // R4 R5 R6: cycle-steal flag against both poll classes, irq disabled
        for (int c = 0; c < 2; c++) begin
            for (int k = 0; k < 2; k++) begin
                logic hit;
                hit = (c == 1) && (k == 0);
                prep_load = 1; prep_ien = 0; irq_clr = 1;
                cs_set = c[0]; cs_clr = !c[0]; cap_release = 1;
                tick(); quiet();
                check("R4 cs flag", 32'(cs_req_out), 32'(c));
                poll_active = 1; poll_cs_n = k[0]; poll_level = '0;
                tick(); quiet();
                check(hit ? "R5 held" : "R6 held", 32'(poll_held), 32'(hit));
                check(hit ? "R5 pass" : "R6 pass", 32'(poll_pass), 32'(!hit));
                check("R5 kind", 32'(held_irq), 0);
                tick();
            end
        end

        // R4: clear wins over set
        cs_set = 1; cs_clr = 1; tick(); quiet();
        check("R4 clr wins", 32'(cs_req_out), 0);
        cs_set = 1; tick(); quiet();
        check("R4 set", 32'(cs_req_out), 1);

        // R8: held poll passes further polls, release clears
        cap_release = 1; tick(); quiet();
        poll_active = 1; poll_cs_n = 0; tick(); quiet();
        check("R8 capture", 32'(poll_held), 1);
        poll_active = 1; poll_cs_n = 0; tick(); quiet();
        check("R8 held pass", 32'(poll_pass), 1);
        check("R8 still held", 32'(poll_held), 1);
        tick(); tick();
        check("R8 no self clear", 32'(poll_held), 1);
        cap_release = 1; tick(); quiet();
        check("R8 release", 32'(poll_held), 0);

        // R2: reload while idle moves the request line
        irq_set = 1; prep_load = 1; prep_ien = 1; prep_level = 4'd3; tick(); quiet();
        check("R2 first load", 32'(reqin_bus), 32'd1 << 3);
        prep_load = 1; prep_level = 4'd12; tick(); quiet();
        check("R2 reload", 32'(reqin_bus), 32'd1 << 12);
        poll_active = 1; poll_cs_n = 1; poll_level = 4'd3; tick(); quiet();
        check("R2 old level passed", 32'(poll_pass), 1);
        poll_active = 1; poll_level = 4'd12; tick(); quiet();
        check("R2 new level held", 32'(poll_held), 1);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule